// File: doc/BRIEF.md
# Reset Pin Filter and Release Sequencer

This block merges the reset requests of a chip into a single active-low internal reset. It watches an asynchronous, active-low reset pin and a watchdog-timeout request from the on-chip timer. It also takes a power-on clear input. The pin is first brought into the oscillator clock domain by a synchronizer. A digital filter then decides whether a low level on the pin is real. Brief low spikes are thrown away. A sustained low level is always accepted. Short high spikes that interrupt a low level do not discard the low time already counted.

When every source has gone quiet, the block counts a fixed number of oscillator cycles before it lets the core run. The default count is 20479 cycles. A pin release is recognised only after a qualification delay of consecutive high samples. Any new request that arrives during the count starts the whole sequence again. In the first cycle after release, a one-cycle strobe starts the boot phase. That phase fetches the reset vector from the lowest two bytes of memory, which is outside this block. A small cause register tells the boot code where the last reset came from.

The watchdog request never reaches the pin, because the block has no pin driver at all. All pins are plain control signals. No data flows through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Once ACCEPT_CYC low samples have accumulated, the pin asserts the internal reset. With the default two synchronizer stages, for an uninterrupted low starting at cycle 0, `core_rst_n` reads 0 at cycle ACCEPT_CYC+3.
- R2: A low pulse that is followed by at least GLITCH_CYC high cycles is ignored if it is shorter than ACCEPT_CYC cycles. In that case `core_rst_n` stays 1 and `rst_cause` keeps its value.
- R3: If a high interruption inside a low period is shorter than GLITCH_CYC cycles, the low samples counted so far are kept. A high run of GLITCH_CYC cycles or more discards them.
- R4: While the pin reset is held, a release needs QUAL_CYC consecutive high samples. If the pin is high from cycle e onward, `core_rst_n` reads 1 at cycle e+3+QUAL_CYC+RELEASE_CYC.
- R5: After all sources go inactive, the internal reset stays asserted for exactly RELEASE_CYC cycles (default 20479) of the release count.
- R6: `wdog_req` is a synchronous, active-high request with no filter. If it is high in cycle 0, `core_rst_n` reads 0 at cycle 1. If its last high cycle is h, `core_rst_n` reads 1 at cycle h+2+RELEASE_CYC.
- R7: A request from either source during the release count keeps the reset asserted and restarts the full count.
- R8: `rst_cause` encodes the last reset source as 2'b00 for power-on, 2'b01 for pin and 2'b10 for watchdog. It is rewritten every cycle in which a source is active. When the filtered pin and the watchdog are both active in the same cycle, the pin wins.
- R9: `por_n` low asserts `core_rst_n` asynchronously and clears `rst_cause` to 2'b00, `boot_go` to 0 and the filter. If `por_n` rises before cycle 1 while the pin is high, `core_rst_n` reads 1 at cycle 1+RELEASE_CYC.
- R10: `boot_go` is high for exactly one cycle. That cycle is the first one in which `core_rst_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| pin_rst_n | input | 1 | External reset pin after the input buffer, active low, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request, active high, synchronous to clk_osc |
| core_rst_n | output | 1 | Internal reset, active low; asserts asynchronously, releases on a clock edge |
| rst_cause | output | 2 | Source of the last reset (00 power-on, 01 pin, 10 watchdog) |
| boot_go | output | 1 | One-cycle strobe that starts the boot phase |

## Verification
Each result has a fixed latency from the stimulus that causes it. A pin assertion shows up ACCEPT_CYC+3 cycles after the first low cycle, or later by the length of a tolerated high interruption. A pin release shows up QUAL_CYC+RELEASE_CYC+3 cycles after the pin goes high. A watchdog request asserts one cycle after it goes high, and releases RELEASE_CYC+2 cycles after its last high cycle. The bench numbers every cycle from the one in which it drives a pattern. It reads the outputs at the falling edge and records the exact index of the reset fall, the reset rise and each strobe. It then compares those indices with values computed from the pattern lengths and the parameters. No tolerance window is allowed.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    CAUSE_POR  = 2'b00,
    CAUSE_PIN  = 2'b01,
    CAUSE_WDOG = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    SQ_HOLD  = 2'b00,
    SQ_COUNT = 2'b01,
    SQ_RUN   = 2'b10
  } seq_e;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= RST_VAL;
        else         chain <= d;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int GLITCH_CYC = 13,
  parameter int ACCEPT_CYC = 5000,
  parameter int QUAL_CYC   = 1000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_s,
  output logic pin_hold
);

  localparam int LW = $clog2(ACCEPT_CYC + 1);
  localparam int HW = $clog2(GLITCH_CYC + 1);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int RW = $clog2(QUAL_CYC + 2);

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic [QW-1:0] q_cnt;
  logic          hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      q_cnt  <= '0;
      hold_q <= 1'b0;
    end else if (!hold_q) begin
      q_cnt <= '0;
      if (!pin_s) begin
        hi_cnt <= '0;
        if (lo_cnt == LW'(ACCEPT_CYC - 1)) begin
          hold_q <= 1'b1;
          lo_cnt <= '0;
        end else begin
          lo_cnt <= lo_cnt + LW'(1);
        end
      end else if (hi_cnt >= HW'(GLITCH_CYC - 1)) begin
        lo_cnt <= '0;
      end else begin
        hi_cnt <= hi_cnt + HW'(1);
      end
    end else begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      if (!pin_s) begin
        q_cnt <= '0;
      end else if (q_cnt == QW'(QUAL_CYC - 1)) begin
        hold_q <= 1'b0;
        q_cnt  <= '0;
      end else begin
        q_cnt <= q_cnt + QW'(1);
      end
    end
  end

  assign pin_hold = hold_q;

  // independent run length of consecutive high samples, for checking only
  logic [RW-1:0] hi_run;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                         hi_run <= '0;
    else if (!pin_s)                     hi_run <= '0;
    else if (hi_run != RW'(QUAL_CYC + 1)) hi_run <= hi_run + RW'(1);
  end

  // R1
  accept_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(hold_q) |-> $past(!pin_s));

  // R4
  qual_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(hold_q) |-> (hi_run >= RW'(QUAL_CYC)));

endmodule

// File: rtl/rsq_release_seq.sv
module rsq_release_seq
  import rsq_pkg::*;
#(
  parameter int RELEASE_CYC = 20479
) (
  input  logic   clk,
  input  logic   arst_n,
  input  logic   pin_hold,
  input  logic   wdog_req,
  output logic   core_rst_n,
  output cause_e cause,
  output logic   boot_go
);

  localparam int CW = $clog2(RELEASE_CYC + 1);
  localparam int SW = $clog2(RELEASE_CYC + 2);

  seq_e          state;
  logic [CW-1:0] cnt;
  logic          rst_q;
  logic          boot_q;
  cause_e        cause_q;
  logic          src;

  assign src = pin_hold | wdog_req;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state   <= SQ_HOLD;
      cnt     <= '0;
      rst_q   <= 1'b0;
      boot_q  <= 1'b0;
      cause_q <= CAUSE_POR;
    end else begin
      boot_q <= 1'b0;
      if (src) begin
        state   <= SQ_HOLD;
        cnt     <= '0;
        rst_q   <= 1'b0;
        cause_q <= pin_hold ? CAUSE_PIN : CAUSE_WDOG;
      end else begin
        case (state)
          SQ_HOLD: begin
            state <= SQ_COUNT;
            cnt   <= '0;
          end
          SQ_COUNT: begin
            if (cnt == CW'(RELEASE_CYC - 1)) begin
              state  <= SQ_RUN;
              rst_q  <= 1'b1;
              boot_q <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          SQ_RUN: state <= SQ_RUN;
          default: begin
            state <= SQ_HOLD;
            rst_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign core_rst_n = rst_q;
  assign cause      = cause_q;
  assign boot_go    = boot_q;

  // count of consecutive quiet cycles, for checking only
  logic [SW-1:0] quiet_run;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                               quiet_run <= '0;
    else if (src)                              quiet_run <= '0;
    else if (quiet_run != SW'(RELEASE_CYC + 1)) quiet_run <= quiet_run + SW'(1);
  end

  // R5
  release_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst_n) |-> (quiet_run == SW'(RELEASE_CYC + 1)));

  // R7
  src_holds_chk: assert property (@(posedge clk) disable iff (!arst_n)
    src |=> !core_rst_n);

  // R8
  pin_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pin_hold |=> (cause == CAUSE_PIN));

  // R6
  wdog_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (wdog_req && !pin_hold) |=> (cause == CAUSE_WDOG));

  // R10
  boot_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    boot_go |=> !boot_go);

  // R10
  boot_on_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst_n) |-> boot_go);

  // R10
  boot_in_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
    boot_go |-> core_rst_n);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 13,
  parameter int ACCEPT_CYC  = 5000,
  parameter int QUAL_CYC    = 1000,
  parameter int RELEASE_CYC = 20479
) (
  input  logic       clk_osc,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       wdog_req,
  output logic       core_rst_n,
  output logic [1:0] rst_cause,
  output logic       boot_go
);

  logic   pin_s;
  logic   pin_hold;
  cause_e cause_w;

  rsq_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk    (clk_osc),
    .arst_n (por_n),
    .d      (pin_rst_n),
    .q      (pin_s)
  );

  rsq_pin_filter #(
    .GLITCH_CYC (GLITCH_CYC),
    .ACCEPT_CYC (ACCEPT_CYC),
    .QUAL_CYC   (QUAL_CYC)
  ) u_filter (
    .clk      (clk_osc),
    .arst_n   (por_n),
    .pin_s    (pin_s),
    .pin_hold (pin_hold)
  );

  rsq_release_seq #(
    .RELEASE_CYC (RELEASE_CYC)
  ) u_seq (
    .clk        (clk_osc),
    .arst_n     (por_n),
    .pin_hold   (pin_hold),
    .wdog_req   (wdog_req),
    .core_rst_n (core_rst_n),
    .cause      (cause_w),
    .boot_go    (boot_go)
  );

  assign rst_cause = cause_w;

endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;

  localparam int G  = 3;
  localparam int A  = 8;
  localparam int Q  = 4;
  localparam int RL = 24;
  localparam int DEF_RL = 20479;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       wd = 1'b0;
  logic       core;
  logic [1:0] cause;
  logic       boot;

  logic       wd_d = 1'b0;
  logic       core_d;
  logic [1:0] cause_d;
  logic       boot_d;

  int checks = 0;
  int errors = 0;
  int cur_cause = 0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(
    .SYNC_STAGES (2),
    .GLITCH_CYC  (G),
    .ACCEPT_CYC  (A),
    .QUAL_CYC    (Q),
    .RELEASE_CYC (RL)
  ) uut (
    .clk_osc    (clk),
    .por_n      (por_n),
    .pin_rst_n  (pin_n),
    .wdog_req   (wd),
    .core_rst_n (core),
    .rst_cause  (cause),
    .boot_go    (boot)
  );

  rst_seq_ctrl uut_dflt (
    .clk_osc    (clk),
    .por_n      (por_n),
    .pin_rst_n  (1'b1),
    .wdog_req   (wd_d),
    .core_rst_n (core_d),
    .rst_cause  (cause_d),
    .boot_go    (boot_d)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic pin_at(input int t, input int pa, input int pb, input int pc);
    return ((t < pa) || (t >= pa + pb && t < pa + pb + pc)) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic wd_at(input int t, input int w0, input int w1, input int w2);
    return ((t >= w0 && t < w1) || t == w2) ? 1'b1 : 1'b0;
  endfunction

  // pin low for pa, high for pb, low for pc; watchdog high in [w0,w1) and at w2
  task automatic run(input int pa, input int pb, input int pc,
                     input int w0, input int w1, input int w2,
                     input int exp_lo, input int exp_hi, input int exp_cause,
                     input string tag_a, input string tag_r);
    int last;
    int tlen;
    int t_lo;
    int t_hi;
    int boots;
    int boot_at;
    last = pa + pb + pc;
    if (w1 > last) last = w1;
    if (w2 + 1 > last) last = w2 + 1;
    tlen = last + Q + RL + 12;
    t_lo = -1;
    t_hi = -1;
    boots = 0;
    boot_at = -1;
    @(negedge clk);
    pin_n = pin_at(0, pa, pb, pc);
    wd = wd_at(0, w0, w1, w2);
    for (int t = 1; t < tlen; t++) begin
      @(negedge clk);
      if (core == 1'b0 && t_lo < 0) t_lo = t;
      if (core == 1'b1 && t_lo >= 0 && t_hi < 0) t_hi = t;
      if (boot) begin
        boots++;
        boot_at = t;
      end
      pin_n = pin_at(t, pa, pb, pc);
      wd = wd_at(t, w0, w1, w2);
    end
    chk({tag_a, " reset assert cycle"}, t_lo, exp_lo);
    chk({tag_r, " reset release cycle"}, t_hi, exp_hi);
    chk("R10 boot strobe count", boots, (exp_lo >= 0) ? 1 : 0);
    chk("R10 boot strobe cycle", boot_at, exp_hi);
    chk("R8 reset cause", int'(cause), exp_cause);
    if (exp_lo >= 0) cur_cause = exp_cause;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_up();
  end

  initial begin
    int t_hi;
    // R9: state under power-on clear
    repeat (3) @(negedge clk);
    chk("R9 core reset under por", int'(core), 0);
    chk("R9 cause under por", int'(cause), 0);
    chk("R9 boot under por", int'(boot), 0);
    por_n = 1'b1;
    t_hi = -1;
    for (int t = 1; t < RL + 8; t++) begin
      @(negedge clk);
      if (core && t_hi < 0) begin
        t_hi = t;
        chk("R10 boot after por release", int'(boot), 1);
      end
    end
    chk("R9 release after por", t_hi, 1 + RL);

    // R1 R2: single low pulse sweep
    for (int w = 1; w <= A + 4; w++) begin
      if (w >= A) run(w, 0, 0, 0, 0, -1, A + 3, w + 3 + Q + RL, 1, "R1", "R4 R5");
      else        run(w, 0, 0, 0, 0, -1, -1, -1, cur_cause, "R2", "R2");
    end

    // R3: high interruptions inside a low period
    for (int a = 1; a < A; a++) begin
      for (int b = 1; b <= G; b++) begin
        if (b < G) begin
          run(a, b, A - a, 0, 0, -1, b + A + 3, b + A + 3 + Q + RL, 1, "R3", "R4");
          if (A - a - 1 > 0)
            run(a, b, A - a - 1, 0, 0, -1, -1, -1, cur_cause, "R3", "R3");
        end else begin
          run(a, b, A - a, 0, 0, -1, -1, -1, cur_cause, "R3", "R3");
        end
      end
    end

    // R6: watchdog windows of several lengths
    for (int wl = 1; wl <= 5; wl++)
      run(0, 0, 0, 0, wl, -1, 1, wl + 1 + RL, 2, "R6", "R6");

    // R7: watchdog pulse during the release count after a watchdog reset
    run(0, 0, 0, 0, 3, 3 + 10, 1, 3 + 10 + 2 + RL, 2, "R7", "R7");
    // R7: watchdog pulse during the release count after a pin reset
    run(A, 0, 0, -1, -1, A + Q + 10, A + 3, A + Q + 10 + 2 + RL, 2, "R7", "R7");
    // R7: second accepted pin low during the release count
    run(A, Q + 6, A, 0, 0, -1, A + 3, 2 * A + Q + 6 + 3 + Q + RL, 1, "R7", "R7");

    // R8: pin and watchdog both active in their final cycle, pin wins
    run(A + 5, 0, 0, 12, 19, -1, A + 3, 44, 1, "R8", "R8");

    // R5: default instance, release count of 20479 cycles
    wait (core_d == 1'b1);
    @(negedge clk);
    wd_d = 1'b1;
    @(negedge clk);
    wd_d = 1'b0;
    chk("R6 default instance assert", int'(core_d), 0);
    chk("R8 default instance cause", int'(cause_d), 2);
    t_hi = -1;
    for (int t = 2; t < DEF_RL + 10; t++) begin
      @(negedge clk);
      if (core_d && t_hi < 0) t_hi = t;
    end
    chk("R5 default release cycle", t_hi, DEF_RL + 2);

    // R9: asynchronous power-on clear while running
    @(negedge clk);
    chk("R9 running before por", int'(core), 1);
    por_n = 1'b0;
    #1;
    chk("R9 async assert of core reset", int'(core), 0);
    chk("R9 cause cleared", int'(cause), 0);
    @(negedge clk);
    por_n = 1'b1;
    repeat (RL + 4) @(negedge clk);
    chk("R9 running again", int'(core), 1);

    finish_up();
  end

endmodule